// File: doc/BRIEF.md
# Credit-Throttled Configuration Data Streamer

This block moves a configuration image, presented as a stream of 32-bit words with a valid/ready handshake, onto a 32-bit data write port that can apply back-pressure. A sequencer pulses `start` together with the image length in bytes. From then on the block cuts the image into blocks, counts the bytes written and the blocks sent, and reports the outcome with a one-cycle `fin` pulse and a held `status` code.

Two throttling schemes are chosen by `credit_mode`, which is sampled at start. In word mode every 32-bit word is a block of its own and no flow control is applied. In credit mode a block holds `BLOCK_BYTES` bytes. A block may begin only when an 8-bit credit value from the receiver differs from the low eight bits of the local sent-block counter. While no credit is available the block re-probes at a fixed interval derived from the clock frequency. It gives up after a bounded number of probes, or at once if the receiver raises its error flag during the wait. When `chk_en` is set at start, the error flag is also sampled at every `CHECK_BYTES` boundary and once more at the end of the image.

Top module: `cfg_credit_streamer`

## Requirements
- R1: After reset `busy`, `fin`, `wr_valid` and `in_ready` are 0, `status` is 0 (OK), and `bytes_done` and `blocks_sent` are 0.
- R2: In word mode (`credit_mode`=0 at start) each accepted word closes one block, `blocks_sent` rises by one per word, and the credit input is never consulted.
- R3: In credit mode a block starts only in a probe cycle where `credit_val` differs from `blocks_sent` (8-bit, modulo 256). Each block carries `BLOCK_BYTES` bytes except the last, which carries the bytes that remain.
- R4: `bytes_done` and `blocks_sent` are cleared at each accepted start. `blocks_sent` wraps modulo 256 and rises by at most one per cycle.
- R5: Probes occur on the first cycle of a credit wait and then every `TICKS` cycles. If the probe that follows `POLLS` unsuccessful probes still finds no room, the run ends with status 2 (TIMEOUT).
- R6: If a probe finds no room while `cfg_err` is high, the run ends at once with status 1 (RETRY).
- R7: A final word that carries 1 to 3 valid bytes is written with the invalid upper bytes forced to zero. Byte 0 is bits 7:0.
- R8: With `chk_en`=1 at start, `cfg_err` is sampled in the cycle after each block whose end lands on a multiple of `CHECK_BYTES`, and in the cycle after the last word. If it is high, the run ends with status 3 (CFGERR).
- R9: With `chk_en`=0 at start, `cfg_err` has no effect during streaming or at the end of the image.
- R10: A `start` pulse while `busy` is 1 is ignored.
- R11: `fin` is a single-cycle pulse that is seen with `busy`=0. `status` holds its value until the next start. `bytes_done` equals the number of image bytes written.
- R12: A zero-byte image ends with `fin` two cycles after start, status 0, and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an image (ignored while busy) |
| img_bytes | input | CNT_W | Image length in bytes, sampled with start |
| credit_mode | input | 1 | 1 = credit-throttled blocks, 0 = one word per block |
| chk_en | input | 1 | Enable error-flag checks during the run |
| in_valid | input | 1 | Image word available |
| in_data | input | 32 | Image word, byte 0 in bits 7:0 |
| in_ready | output | 1 | Image word taken this cycle when in_valid is also 1 |
| wr_valid | output | 1 | Write request to the data port |
| wr_data | output | 32 | Write data, tail bytes masked |
| wr_ready | input | 1 | Data port accepts the write |
| credit_val | input | 8 | Receiver credit count |
| cfg_err | input | 1 | Receiver configuration error flag |
| busy | output | 1 | Run in progress |
| fin | output | 1 | One-cycle pulse at the end of a run |
| status | output | 2 | 0 OK, 1 RETRY, 2 TIMEOUT, 3 CFGERR |
| bytes_done | output | CNT_W | Bytes written in this run |
| blocks_sent | output | 8 | Blocks written in this run, modulo 256 |

## Verification
The bench builds the block with `CLK_HZ`=1 MHz, `POLL_US`=10 and `TIMEOUT_US`=100, which gives probes every 10 cycles and a timeout after 10 failed probes. The exact timeout latency is therefore checked in about a hundred cycles. `BLOCK_BYTES` and `CHECK_BYTES` are both 16, so multi-block images, credit stalls, error checks at boundaries and a 300-block run that wraps the 8-bit sent counter all fit in a few thousand cycles. Back-pressure and gaps on the input stream are mixed in, and every output is compared against a behavioural model on every clock.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    XS_OK      = 2'd0,
    XS_RETRY   = 2'd1,
    XS_TIMEOUT = 2'd2,
    XS_CFGERR  = 2'd3
  } xfer_status_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CREDIT = 3'd1,
    PH_XFER   = 3'd2,
    PH_CHECK  = 3'd3,
    PH_FINAL  = 3'd4
  } phase_e;

  // room exists when the 8-bit difference is non-zero
  function automatic logic credit_room(input logic [7:0] credit, input logic [7:0] sent);
    logic [7:0] diff;
    diff = credit - sent;
    return diff != 8'd0;
  endfunction

  // nbytes 0 means a full word
  function automatic logic [31:0] tail_mask(input logic [31:0] d, input logic [1:0] nbytes);
    case (nbytes)
      2'd1:    return {24'd0, d[7:0]};
      2'd2:    return {16'd0, d[15:0]};
      2'd3:    return {8'd0, d[23:0]};
      default: return d;
    endcase
  endfunction

  // bytes carried by the next beat given the bytes left in the block
  function automatic logic [2:0] beat_bytes(input logic ge4, input logic [1:0] low);
    return ge4 ? 3'd4 : {1'b0, low};
  endfunction

  function automatic logic on_check_edge(input logic [31:0] done, input logic [31:0] span);
    return (done % span) == 32'd0;
  endfunction

endpackage

// File: rtl/ccs_poll_timer.sv
module ccs_poll_timer #(
  parameter int TICKS = 10,
  parameter int POLLS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic probe,
  output logic expired
);
  localparam int PW = $clog2(TICKS + 1);
  localparam int QW = $clog2(POLLS + 1);

  logic [PW-1:0] pre_q;
  logic [QW-1:0] polls_q;

  assign probe   = run && (pre_q == '0);
  assign expired = (polls_q == QW'(POLLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (clear) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (run) begin
      pre_q <= (pre_q == PW'(TICKS - 1)) ? '0 : pre_q + 1'b1;
      if (probe && !expired) polls_q <= polls_q + 1'b1;
    end
  end
endmodule

// File: rtl/ccs_block_track.sv
module ccs_block_track
  import ccs_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BLOCK_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] img_bytes,
  input  logic             open,
  input  logic             legacy,
  input  logic             beat,
  output logic [CNT_W-1:0] rem_q,
  output logic [CNT_W-1:0] blk_q,
  output logic [CNT_W-1:0] done_q,
  output logic [7:0]       sent_q,
  output logic             blk_end,
  output logic             img_end,
  output logic [CNT_W-1:0] done_nxt
);
  logic [2:0]       k;
  logic [CNT_W-1:0] kx, rem_src, size, blk_len;

  assign k        = beat_bytes(blk_q >= CNT_W'(WORD_BYTES), blk_q[1:0]);
  assign kx       = CNT_W'(k);
  assign rem_src  = load ? img_bytes : (beat ? rem_q - kx : rem_q);
  assign size     = legacy ? CNT_W'(WORD_BYTES) : CNT_W'(BLOCK_BYTES);
  assign blk_len  = (rem_src < size) ? rem_src : size;
  assign blk_end  = beat && (blk_q == kx);
  assign img_end  = beat && (rem_q == kx);
  assign done_nxt = done_q + kx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= '0;
      sent_q <= '0;
    end else if (load) begin
      rem_q  <= img_bytes;
      done_q <= '0;
      sent_q <= '0;
    end else if (beat) begin
      rem_q  <= rem_q - kx;
      done_q <= done_nxt;
      if (blk_end) sent_q <= sent_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     blk_q <= '0;
    else if (open)  blk_q <= blk_len;
    else if (beat)  blk_q <= blk_q - kx;
    else if (load)  blk_q <= '0;
  end
endmodule

// File: rtl/cfg_credit_streamer.sv
module cfg_credit_streamer
  import ccs_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BLOCK_BYTES = 4096,
  parameter int CHECK_BYTES = 4096,
  parameter int CLK_HZ      = 250_000_000,
  parameter int POLL_US     = 10,
  parameter int TIMEOUT_US  = 40_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] img_bytes,
  input  logic             credit_mode,
  input  logic             chk_en,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             wr_valid,
  output logic [31:0]      wr_data,
  input  logic             wr_ready,
  input  logic [7:0]       credit_val,
  input  logic             cfg_err,
  output logic             busy,
  output logic             fin,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] bytes_done,
  output logic [7:0]       blocks_sent
);
  localparam int TICKS_RAW = (CLK_HZ / 1_000_000) * POLL_US;
  localparam int TICKS     = (TICKS_RAW < 1) ? 1 : TICKS_RAW;
  localparam int POLLS     = TIMEOUT_US / POLL_US;

  phase_e       state_q, state_n;
  xfer_status_e stat_q, stat_n;
  logic         fin_q, fin_n;
  logic         cm_q, chk_q;

  logic start_go, legacy, blk_open, beat, grant, probe, expired, tmr_clear;
  logic blk_end, img_end, at_edge;
  logic [CNT_W-1:0] rem_q, blk_q, done_q, done_nxt;
  logic [7:0]       sent_q;

  assign start_go = (state_q == PH_IDLE) && start;
  assign legacy   = start_go ? !credit_mode : !cm_q;
  assign beat     = (state_q == PH_XFER) && in_valid && wr_ready;
  assign grant    = (state_q == PH_CREDIT) && probe && credit_room(credit_val, sent_q);
  assign at_edge  = on_check_edge(32'(done_nxt), 32'(CHECK_BYTES));

  ccs_block_track #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .load(start_go), .img_bytes(img_bytes),
    .open(blk_open), .legacy(legacy), .beat(beat),
    .rem_q(rem_q), .blk_q(blk_q), .done_q(done_q), .sent_q(sent_q),
    .blk_end(blk_end), .img_end(img_end), .done_nxt(done_nxt)
  );

  ccs_poll_timer #(.TICKS(TICKS), .POLLS(POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear),
    .run(state_q == PH_CREDIT), .probe(probe), .expired(expired)
  );

  always_comb begin
    state_n  = state_q;
    stat_n   = stat_q;
    fin_n    = 1'b0;
    blk_open = 1'b0;
    case (state_q)
      PH_IDLE: if (start) begin
        stat_n = XS_OK;
        if (img_bytes == '0)  state_n = PH_FINAL;
        else if (credit_mode) state_n = PH_CREDIT;
        else begin state_n = PH_XFER; blk_open = 1'b1; end
      end
      PH_CREDIT: if (probe) begin
        if (grant) begin
          state_n = PH_XFER; blk_open = 1'b1;
        end else if (cfg_err) begin
          state_n = PH_IDLE; stat_n = XS_RETRY; fin_n = 1'b1;
        end else if (expired) begin
          state_n = PH_IDLE; stat_n = XS_TIMEOUT; fin_n = 1'b1;
        end
      end
      PH_XFER: if (blk_end) begin
        if (img_end)                state_n = PH_FINAL;
        else if (chk_q && at_edge)  state_n = PH_CHECK;
        else if (cm_q)              state_n = PH_CREDIT;
        else blk_open = 1'b1;
      end
      PH_CHECK: begin
        if (cfg_err) begin
          state_n = PH_IDLE; stat_n = XS_CFGERR; fin_n = 1'b1;
        end else if (cm_q) state_n = PH_CREDIT;
        else begin state_n = PH_XFER; blk_open = 1'b1; end
      end
      PH_FINAL: begin
        state_n = PH_IDLE;
        fin_n   = 1'b1;
        stat_n  = (chk_q && cfg_err) ? XS_CFGERR : XS_OK;
      end
      default: state_n = PH_IDLE;
    endcase
  end

  assign tmr_clear = (state_n == PH_CREDIT) && (state_q != PH_CREDIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      stat_q  <= XS_OK;
      fin_q   <= 1'b0;
      cm_q    <= 1'b0;
      chk_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      stat_q  <= stat_n;
      fin_q   <= fin_n;
      if (start_go) begin
        cm_q  <= credit_mode;
        chk_q <= chk_en;
      end
    end
  end

  assign in_ready    = (state_q == PH_XFER) && wr_ready;
  assign wr_valid    = (state_q == PH_XFER) && in_valid;
  assign wr_data     = tail_mask(in_data, (blk_q >= CNT_W'(WORD_BYTES)) ? 2'd0 : blk_q[1:0]);
  assign busy        = (state_q != PH_IDLE);
  assign fin         = fin_q;
  assign status      = stat_q;
  assign bytes_done  = done_q;
  assign blocks_sent = sent_q;
endmodule

// File: rtl/ccs_chk.sv
module ccs_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             fin,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] bytes_done,
  input logic [7:0]       blocks_sent,
  input logic [31:0]      wr_data,
  input logic [7:0]       credit_val,
  input logic             cm_q,
  input logic             grant,
  input logic             beat,
  input logic [CNT_W-1:0] rem_q
);
  // R2
  word_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !cm_q |=> blocks_sent == $past(blocks_sent) + 8'd1);

  // R3
  credit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> credit_val != blocks_sent);

  // R4
  sent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (blocks_sent == $past(blocks_sent)) ||
                            (blocks_sent == $past(blocks_sent) + 8'd1));

  // R5
  timeout_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin && status == 2'd2 |-> cm_q);

  // R7
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && (rem_q < CNT_W'(4)) |-> (wr_data >> {rem_q[1:0], 3'b000}) == 32'd0);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> bytes_done >= $past(bytes_done));

  // R11
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R11
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
endmodule

bind cfg_credit_streamer ccs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fin(fin),
  .status(status), .bytes_done(bytes_done), .blocks_sent(blocks_sent),
  .wr_data(wr_data), .credit_val(credit_val), .cm_q(cm_q), .grant(grant),
  .beat(beat), .rem_q(rem_q)
);

// File: tb/cfg_credit_streamer_test.sv
module cfg_credit_streamer_test;
  localparam int BLK   = 16;
  localparam int CHKB  = 16;
  localparam int TICKS = 10;
  localparam int POLLS = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, credit_mode, chk_en, in_valid, wr_ready, cfg_err;
  logic [31:0] img_bytes, in_data;
  logic [7:0]  credit_val;
  logic in_ready, wr_valid, busy, fin;
  logic [31:0] wr_data, bytes_done;
  logic [1:0]  status;
  logic [7:0]  blocks_sent;

  cfg_credit_streamer #(
    .CNT_W(32), .BLOCK_BYTES(BLK), .CHECK_BYTES(CHKB),
    .CLK_HZ(1_000_000), .POLL_US(10), .TIMEOUT_US(100)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_bytes(img_bytes),
    .credit_mode(credit_mode), .chk_en(chk_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .credit_val(credit_val),
    .cfg_err(cfg_err), .busy(busy), .fin(fin), .status(status),
    .bytes_done(bytes_done), .blocks_sent(blocks_sent)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, widx = 0, fin_cyc = -1;
  string cur_req = "R1";
  bit bp_on = 0, gap_on = 0, cred_auto = 1;
  int cred_fix = 0, err_after = -1;
  // model: 0 idle, 1 credit wait, 2 stream, 3 check, 4 final
  int m_st = 0, m_rem = 0, m_blk = 0, m_done = 0, m_sent = 0;
  int m_pre = 0, m_polls = 0, m_stat = 0;
  bit m_fin = 0, m_cm = 0, m_chk = 0;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] word_of(int i);
    return 32'(i + 1) * 32'h9E3779B9;
  endfunction

  function automatic logic [31:0] keep_bytes(logic [31:0] d, int left);
    logic [31:0] r = 32'd0;
    for (int b = 0; b < 4; b++) if (b < left) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic cmp(string sig, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", cur_req, sig, cyc, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic finish_run(int s);
    m_stat = s; m_fin = 1; m_st = 0;
  endtask

  task automatic open_block();
    m_st = 2; m_blk = imin(m_cm ? BLK : 4, m_rem);
  endtask

  task automatic enter_credit();
    m_st = 1; m_pre = 0; m_polls = 0;
  endtask

  task automatic next_block();
    if (m_cm) enter_credit(); else open_block();
  endtask

  task automatic model_step();
    bit hs;
    int k;
    m_fin = 0;
    hs = (m_st == 2) && in_valid && wr_ready;
    if (hs) widx++;
    case (m_st)
      0: if (start) begin
        m_cm = credit_mode; m_chk = chk_en; m_rem = int'(img_bytes);
        m_done = 0; m_sent = 0; m_stat = 0; m_blk = 0;
        if (m_rem == 0) m_st = 4;
        else if (m_cm) enter_credit();
        else open_block();
      end
      1: begin
        if (m_pre == 0) begin
          if (credit_val != 8'(m_sent)) open_block();
          else if (cfg_err) finish_run(1);
          else if (m_polls == POLLS) finish_run(2);
          else m_polls++;
        end
        if (m_st == 1) m_pre = (m_pre == TICKS - 1) ? 0 : m_pre + 1;
      end
      2: if (hs) begin
        k = imin(4, m_blk);
        m_blk -= k; m_rem -= k; m_done += k;
        if (m_blk == 0) begin
          m_sent = (m_sent + 1) % 256;
          if (m_rem == 0) m_st = 4;
          else if (m_chk && (m_done % CHKB == 0)) m_st = 3;
          else next_block();
        end
      end
      3: if (cfg_err) finish_run(3); else next_block();
      4: finish_run((m_chk && cfg_err) ? 3 : 0);
      default: m_st = 0;
    endcase
  endtask

  // one clock: drive at negedge, compare, advance model, wait for next negedge
  task automatic tick();
    bit e_x;
    in_valid   = gap_on ? (cyc % 7 != 2) : 1'b1;
    wr_ready   = bp_on ? (cyc % 5 != 3) : 1'b1;
    in_data    = word_of(widx);
    credit_val = cred_auto ? 8'(m_sent + 1) : 8'(cred_fix);
    cfg_err    = (err_after >= 0) && (m_done >= err_after);
    #1;
    e_x = (m_st == 2);
    cmp("wr_valid", 64'(wr_valid), 64'(e_x && in_valid));
    cmp("in_ready", 64'(in_ready), 64'(e_x && wr_ready));
    if (e_x && in_valid) cmp("wr_data", 64'(wr_data), 64'(keep_bytes(in_data, m_blk)));
    cmp("busy", 64'(busy), 64'(m_st != 0));
    cmp("fin", 64'(fin), 64'(m_fin));
    cmp("status", 64'(status), 64'(m_stat));
    cmp("bytes_done", 64'(bytes_done), 64'(m_done));
    cmp("blocks_sent", 64'(blocks_sent), 64'(m_sent));
    if (fin) fin_cyc = cyc;
    model_step();
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      summary_and_end();
    end
    @(negedge clk);
  endtask

  task automatic begin_img(int nb, bit cm, bit ck);
    img_bytes = 32'(nb); credit_mode = cm; chk_en = ck; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run_to_fin(int maxc);
    for (int i = 0; i < maxc && !m_fin; i++) tick();
    tick();
  endtask

  task automatic expect_end(string req, int st, int nb, int nblk);
    cur_req = req;
    cmp("end status", 64'(status), 64'(st));
    cmp("end bytes", 64'(bytes_done), 64'(nb));
    cmp("end blocks", 64'(blocks_sent), 64'(nblk));
  endtask

  int s_cyc;

  initial begin
    rst_n = 1'b0; start = 1'b0; img_bytes = '0; credit_mode = 1'b0; chk_en = 1'b0;
    in_valid = 1'b0; in_data = '0; wr_ready = 1'b0; credit_val = '0; cfg_err = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    repeat (3) tick();
    cmp("reset busy", 64'(busy), 64'd0);
    cmp("reset wr_valid", 64'(wr_valid), 64'd0);
    expect_end("R1", 0, 0, 0);

    // R2 R7 word mode, 11 bytes with stalls on both sides
    cur_req = "R2"; bp_on = 1; gap_on = 1;
    begin_img(11, 0, 0); run_to_fin(200);
    expect_end("R2", 0, 11, 3);

    // R3 credit stall then release
    cur_req = "R3"; bp_on = 0; gap_on = 0; cred_auto = 0; cred_fix = 2;
    begin_img(40, 1, 0);
    repeat (40) tick();
    cmp("R3 stalled blocks", 64'(blocks_sent), 64'd2);
    cmp("R3 stalled busy", 64'(busy), 64'd1);
    cred_fix = 3;
    run_to_fin(200);
    expect_end("R3", 0, 40, 3);

    // R7 credit mode with 1-byte tail
    cur_req = "R7"; cred_auto = 1; bp_on = 1;
    begin_img(37, 1, 0); run_to_fin(300);
    expect_end("R7", 0, 37, 3);

    // R5 timeout with exact latency
    cur_req = "R5"; bp_on = 0; cred_auto = 0; cred_fix = 0;
    s_cyc = cyc;
    begin_img(32, 1, 0); run_to_fin(400);
    expect_end("R5", 2, 0, 0);
    cmp("R5 latency", 64'(fin_cyc - s_cyc), 64'(POLLS * TICKS + 2));

    // R6 error during credit wait
    cur_req = "R6"; err_after = 0;
    begin_img(32, 1, 0); run_to_fin(100);
    expect_end("R6", 1, 0, 0);

    // R8 error caught at a check boundary
    cur_req = "R8"; cred_auto = 1; err_after = 20;
    begin_img(64, 1, 1); run_to_fin(300);
    expect_end("R8", 3, 32, 2);

    // R8 error caught at the end of the image
    err_after = 8;
    begin_img(8, 0, 1); run_to_fin(100);
    expect_end("R8", 3, 8, 2);

    // R9 error flag ignored when checks are off
    cur_req = "R9"; err_after = 0; gap_on = 1;
    begin_img(20, 0, 0); run_to_fin(200);
    expect_end("R9", 0, 20, 5);
    err_after = -1;

    // R12 empty image
    cur_req = "R12"; s_cyc = cyc;
    begin_img(0, 0, 0); run_to_fin(20);
    expect_end("R12", 0, 0, 0);
    cmp("R12 latency", 64'(fin_cyc - s_cyc), 64'd2);

    // R10 restart while busy is ignored
    cur_req = "R10";
    begin_img(24, 0, 0);
    repeat (3) tick();
    img_bytes = 32'd4; start = 1'b1; tick(); start = 1'b0;
    run_to_fin(200);
    expect_end("R10", 0, 24, 6);

    // R4 long credit run wrapping the sent counter
    cur_req = "R4"; gap_on = 0; bp_on = 1;
    begin_img(BLK * 300, 1, 1); run_to_fin(20000);
    expect_end("R4", 0, BLK * 300, 300 % 256);

    // R11 fin went low again and status held
    cur_req = "R11";
    repeat (3) tick();
    cmp("R11 fin low", 64'(fin), 64'd0);
    cmp("R11 status held", 64'(status), 64'd0);

    summary_and_end();
  end
endmodule